// File: doc/BRIEF.md
# Variable-Length Instruction Byte Decoder

This block sits between a byte fetch path and an execution stage of a small 8-bit accumulator processor. Instruction bytes arrive one per accepted transfer on a valid/ready input. The first byte of each instruction is sorted into one of twenty classes by its fixed bit patterns. The embedded 3-bit fields are pulled out of that byte: register indices, ALU function, condition code, port number and restart slot. Depending on the class, the block then gathers no, one or two more bytes, which are either immediate data or a little-endian 16-bit address.

Once the last byte is in, the block presents one decoded record on a valid/ready output. It holds the record unchanged until the consumer takes it, and it accepts no new byte while a record is waiting. Byte patterns that match no defined form are flagged as illegal and reported as one-byte instructions, so the stream stays in step. The block does not execute instructions, fetch from memory or keep a program counter.

Top module: `ibd_decoder`

## Requirements
- R1: `in_ready` is low whenever `out_valid` is high. `out_valid` rises only after a byte was accepted in the previous cycle. While `out_valid` is high and `out_ready` is low, every output field stays unchanged. The cycle after `out_valid && out_ready`, `out_valid` is low and `in_ready` is high.
- R2: While `rst` is sampled high at a clock edge, no byte is taken. After that edge, `out_valid` is 0 and `in_ready` is 1, and the next accepted byte is treated as the first byte of an instruction, even if an instruction was only partly collected.
- R3: Register fields use A=0, B=1, C=2, D=3, E=4, H=5, L=6, M=7. Byte `10 fff sss` gives kind 18 (register ALU), with `out_alu`=bits[5:3] and `out_src`=bits[2:0]. Byte `11 ddd sss` (except 0xFF) gives kind 19 (copy), with `out_dst`=bits[5:3] and `out_src`=bits[2:0]. Both are one byte long.
- R4: Bytes 0x00, 0x01 and 0xFF give kind 0 (halt), with length 1.
- R5: Byte `00 ddd 000` gives kind 1 (increment) and `00 ddd 001` gives kind 2 (decrement), each with `out_dst`=ddd, for ddd in 1..6. For ddd=7 these bytes are illegal.
- R6: Byte `00 fff 100` gives kind 7 (ALU with immediate), with `out_alu`=fff. Byte `00 ddd 110` gives kind 8 (load immediate), with `out_dst`=ddd. Both have length 2, and `out_imm` equals the second byte.
- R7: Byte `00 xxx 111` gives kind 9 (return). Byte `00 ccc 011` gives kind 10 (conditional return), with `out_cond`=ccc. Byte `00 nnn 101` gives kind 11 (restart), with `out_target`=nnn×8. All three have length 1.
- R8: Each of these forms has length 3, and `out_target` = {third byte, second byte}:
  - `01 ccc 000` gives kind 13 (conditional jump).
  - `01 xxx 100` gives kind 12 (jump).
  - `01 ccc 010` gives kind 15 (conditional call).
  - `01 xxx 110` gives kind 14 (call).
  
  For the two conditional forms, `out_cond`=ccc.
- R9: Byte `01 00 ppp 1` gives kind 16 (input), with `out_port`=bits[3:1]. Any other `01 xxxxx 1` byte gives kind 17 (output), with `out_port`=bits[5:1], which lies in 8..31. Both have length 1.
- R10: Bytes 0x02, 0x0A, 0x12 and 0x1A give kinds 3, 4, 5 and 6 (the four accumulator rotates), each with length 1.
- R11: Bytes 0x22, 0x2A, 0x32, 0x3A, 0x38 and 0x39 give kind 20 with `out_illegal`=1 and length 1. For every other byte, `out_illegal` is 0.
- R12: A record field that its class does not use reads 0. In particular, `out_imm` is 0 for every kind other than 7 and 8, and `out_target` is 0 for every kind other than 11 through 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte will be taken at this edge |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_kind | output | 5 | Instruction class code |
| out_dst | output | 3 | Destination register index |
| out_src | output | 3 | Source register index |
| out_alu | output | 3 | ALU function |
| out_cond | output | 3 | Condition code |
| out_port | output | 5 | I/O port number |
| out_imm | output | 8 | Immediate data byte |
| out_target | output | 16 | Branch, call or restart address |
| out_len | output | 2 | Instruction length in bytes (1 to 3) |
| out_illegal | output | 1 | Undefined byte pattern |

## Verification
The bench feeds every one of the 256 first-byte values in turn, each followed by the operand bytes its class needs. Gaps on the input and stalls on the output come from a pseudo-random sequence. This catches the overlapping patterns:
- A design that checks increment before halt would report 0x00 as an increment of A.
- A design that lets the output form capture bits[5:4]=00 would send ports 0–7 to the wrong class.
- A design that counts the illegal `00 1xx 010` bytes as longer than one byte would swallow the following opcode.

A reset is applied in the middle of a three-byte branch. A decoder that keeps the partial count would then decode the remaining address byte as an operand and not as a new opcode. Stalled outputs show whether the record or `in_ready` moves while a result is waiting.

// File: rtl/ibd_pkg.sv
package ibd_pkg;

    localparam int BYTE_W  = 8;
    localparam int FIELD_W = 3;
    localparam int PORT_W  = 5;
    localparam int MAX_OPS = 2;
    localparam int ADDR_W  = MAX_OPS * BYTE_W;
    localparam int CNT_W   = $clog2(MAX_OPS + 1);
    localparam int LEN_W   = $clog2(MAX_OPS + 2);
    localparam int KIND_W  = 5;

    typedef enum logic [KIND_W-1:0] {
        K_HALT      = 5'd0,
        K_INC       = 5'd1,
        K_DEC       = 5'd2,
        K_ROT_LC    = 5'd3,
        K_ROT_RC    = 5'd4,
        K_ROT_L     = 5'd5,
        K_ROT_R     = 5'd6,
        K_ALU_IMM   = 5'd7,
        K_LOAD_IMM  = 5'd8,
        K_RET       = 5'd9,
        K_RET_COND  = 5'd10,
        K_RESTART   = 5'd11,
        K_JUMP      = 5'd12,
        K_JUMP_COND = 5'd13,
        K_CALL      = 5'd14,
        K_CALL_COND = 5'd15,
        K_INPUT     = 5'd16,
        K_OUTPUT    = 5'd17,
        K_ALU_REG   = 5'd18,
        K_COPY      = 5'd19,
        K_ILLEGAL   = 5'd20
    } insn_kind_e;

    typedef struct packed {
        insn_kind_e          kind;
        logic [FIELD_W-1:0]  dst;
        logic [FIELD_W-1:0]  src;
        logic [FIELD_W-1:0]  alu;
        logic [FIELD_W-1:0]  cond;
        logic [PORT_W-1:0]   port;
        logic [ADDR_W-1:0]   vec;
        logic [CNT_W-1:0]    nops;
    } first_info_t;

    function automatic logic kind_has_imm(insn_kind_e k);
        return (k == K_ALU_IMM) || (k == K_LOAD_IMM);
    endfunction

    function automatic logic kind_has_addr(insn_kind_e k);
        return (k == K_JUMP) || (k == K_JUMP_COND) || (k == K_CALL) || (k == K_CALL_COND);
    endfunction

endpackage

// File: rtl/ibd_classify.sv
module ibd_classify
    import ibd_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output first_info_t       info
);
    logic [1:0]         grp;
    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] lo;

    assign grp = op[7:6];
    assign hi  = op[5:3];
    assign lo  = op[2:0];

    always_comb begin
        info      = '0;
        info.kind = K_ILLEGAL;
        unique case (grp)
            2'b00: begin
                unique case (lo)
                    3'b000, 3'b001: begin
                        if (hi == 3'd0)      info.kind = K_HALT;
                        else if (hi == 3'd7) info.kind = K_ILLEGAL;
                        else begin
                            info.kind = lo[0] ? K_DEC : K_INC;
                            info.dst  = hi;
                        end
                    end
                    3'b010: begin
                        if (!hi[2]) begin
                            unique case (hi[1:0])
                                2'b00: info.kind = K_ROT_LC;
                                2'b01: info.kind = K_ROT_RC;
                                2'b10: info.kind = K_ROT_L;
                                default: info.kind = K_ROT_R;
                            endcase
                        end
                    end
                    3'b011: begin info.kind = K_RET_COND; info.cond = hi; end
                    3'b100: begin info.kind = K_ALU_IMM; info.alu = hi; info.nops = CNT_W'(1); end
                    3'b101: begin
                        info.kind = K_RESTART;
                        info.vec  = ADDR_W'({hi, 3'b000});
                    end
                    3'b110: begin info.kind = K_LOAD_IMM; info.dst = hi; info.nops = CNT_W'(1); end
                    default: info.kind = K_RET;
                endcase
            end
            2'b01: begin
                if (lo[0]) begin
                    if (hi[2:1] == 2'b00) begin
                        info.kind = K_INPUT;
                        info.port = PORT_W'(op[3:1]);
                    end else begin
                        info.kind = K_OUTPUT;
                        info.port = op[5:1];
                    end
                end else begin
                    info.nops = CNT_W'(MAX_OPS);
                    unique case (lo[2:1])
                        2'b00: begin info.kind = K_JUMP_COND; info.cond = hi; end
                        2'b01: begin info.kind = K_CALL_COND; info.cond = hi; end
                        2'b10: info.kind = K_JUMP;
                        default: info.kind = K_CALL;
                    endcase
                end
            end
            2'b10: begin
                info.kind = K_ALU_REG;
                info.alu  = hi;
                info.src  = lo;
            end
            default: begin
                if (op == '1) info.kind = K_HALT;
                else begin
                    info.kind = K_COPY;
                    info.dst  = hi;
                    info.src  = lo;
                end
            end
        endcase
    end
endmodule

// File: rtl/ibd_operand_buf.sv
module ibd_operand_buf
    import ibd_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [CNT_W-1:0]                 wr_idx,
    input  logic [BYTE_W-1:0]                wr_byte,
    output logic [MAX_OPS-1:0][BYTE_W-1:0]   ops
);
    for (genvar i = 0; i < MAX_OPS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                ops[i] <= '0;
            else if (wr_en && (wr_idx == CNT_W'(i)))
                ops[i] <= wr_byte;
        end
    end
endmodule

// File: rtl/ibd_decoder.sv
module ibd_decoder
    import ibd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    output logic                 in_ready,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [4:0]           out_kind,
    output logic [2:0]           out_dst,
    output logic [2:0]           out_src,
    output logic [2:0]           out_alu,
    output logic [2:0]           out_cond,
    output logic [4:0]           out_port,
    output logic [7:0]           out_imm,
    output logic [15:0]          out_target,
    output logic [1:0]           out_len,
    output logic                 out_illegal
);
    typedef enum logic [1:0] { ST_FIRST, ST_OPS, ST_HOLD } seq_state_e;

    seq_state_e                     state_q;
    first_info_t                    info_d, info_q;
    logic [CNT_W-1:0]               got_q;
    logic [MAX_OPS-1:0][BYTE_W-1:0] ops;
    logic                           accept;

    ibd_classify u_classify (
        .op   (in_byte),
        .info (info_d)
    );

    assign in_ready = (state_q != ST_HOLD);
    assign accept   = in_valid && in_ready;

    ibd_operand_buf u_opbuf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept && (state_q == ST_OPS)),
        .wr_idx  (got_q),
        .wr_byte (in_byte),
        .ops     (ops)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FIRST;
            info_q  <= '0;
            got_q   <= '0;
        end else begin
            unique case (state_q)
                ST_FIRST: if (in_valid) begin
                    info_q  <= info_d;
                    got_q   <= '0;
                    state_q <= (info_d.nops == '0) ? ST_HOLD : ST_OPS;
                end
                ST_OPS: if (in_valid) begin
                    got_q <= got_q + CNT_W'(1);
                    if (got_q + CNT_W'(1) == info_q.nops)
                        state_q <= ST_HOLD;
                end
                default: if (out_ready) state_q <= ST_FIRST;
            endcase
        end
    end

    assign out_valid   = (state_q == ST_HOLD);
    assign out_kind    = info_q.kind;
    assign out_dst     = info_q.dst;
    assign out_src     = info_q.src;
    assign out_alu     = info_q.alu;
    assign out_cond    = info_q.cond;
    assign out_port    = info_q.port;
    assign out_illegal = (info_q.kind == K_ILLEGAL);
    assign out_len     = LEN_W'(info_q.nops) + LEN_W'(1);
    assign out_imm     = kind_has_imm(info_q.kind) ? ops[0] : '0;
    assign out_target  = kind_has_addr(info_q.kind) ? ops
                       : (info_q.kind == K_RESTART) ? info_q.vec : '0;
endmodule

// File: rtl/ibd_decoder_chk.sv
module ibd_decoder_chk
    import ibd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [4:0]  out_kind,
    input logic [7:0]  out_imm,
    input logic [15:0] out_target,
    input logic [1:0]  out_len,
    input logic        out_illegal
);
    p_hold_blocks_input_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_record_stable_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind)
                                       && $stable(out_imm) && $stable(out_target)
                                       && $stable(out_len)));

    p_rise_after_byte_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    p_reset_idle_r2: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    p_halt_short_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 5'd0) |-> (out_len == 2'd1));

    p_branch_long_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind >= 5'd12 && out_kind <= 5'd15) |-> (out_len == 2'd3));

    p_illegal_short_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_len == 2'd1 && out_kind == 5'd20));

    p_unused_imm_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != 5'd7 && out_kind != 5'd8) |-> (out_imm == 8'd0));
endmodule

bind ibd_decoder ibd_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_kind    (out_kind),
    .out_imm     (out_imm),
    .out_target  (out_target),
    .out_len     (out_len),
    .out_illegal (out_illegal)
);

// File: tb/ibd_decoder_tb.sv
module ibd_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'd0;
    logic        out_ready = 1'b0;
    logic        in_ready, out_valid, out_illegal;
    logic [4:0]  out_kind, out_port;
    logic [2:0]  out_dst, out_src, out_alu, out_cond;
    logic [7:0]  out_imm;
    logic [15:0] out_target;
    logic [1:0]  out_len;

    ibd_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_dst(out_dst), .out_src(out_src),
        .out_alu(out_alu), .out_cond(out_cond), .out_port(out_port),
        .out_imm(out_imm), .out_target(out_target), .out_len(out_len),
        .out_illegal(out_illegal)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference decode: kind, fields and total length
    task automatic ref_decode(input logic [7:0] b, output int k, output int d,
                              output int s, output int a, output int c,
                              output int p, output int v, output int len);
        k = 20; d = 0; s = 0; a = 0; c = 0; p = 0; v = 0; len = 1;
        casez (b)
            8'b0000000?: k = 0;
            8'b11111111: k = 0;
            8'b0011100?: k = 20;
            8'b00???000: begin k = 1; d = b[5:3]; end
            8'b00???001: begin k = 2; d = b[5:3]; end
            8'b00000010: k = 3;
            8'b00001010: k = 4;
            8'b00010010: k = 5;
            8'b00011010: k = 6;
            8'b00???010: k = 20;
            8'b00???011: begin k = 10; c = b[5:3]; end
            8'b00???100: begin k = 7; a = b[5:3]; len = 2; end
            8'b00???101: begin k = 11; v = 8 * b[5:3]; end
            8'b00???110: begin k = 8; d = b[5:3]; len = 2; end
            8'b00???111: k = 9;
            8'b01???000: begin k = 13; c = b[5:3]; len = 3; end
            8'b01???100: begin k = 12; len = 3; end
            8'b01???010: begin k = 15; c = b[5:3]; len = 3; end
            8'b01???110: begin k = 14; len = 3; end
            8'b0100???1: begin k = 16; p = b[3:1]; end
            8'b01?????1: begin k = 17; p = b[5:1]; end
            8'b10??????: begin k = 18; a = b[5:3]; s = b[2:0]; end
            default:     begin k = 19; d = b[5:3]; s = b[2:0]; end
        endcase
    endtask

    function automatic string req_for(input int k);
        if (k == 0) return "R4";
        if (k == 1 || k == 2) return "R5";
        if (k >= 3 && k <= 6) return "R10";
        if (k == 7 || k == 8) return "R6";
        if (k >= 9 && k <= 11) return "R7";
        if (k >= 12 && k <= 15) return "R8";
        if (k == 16 || k == 17) return "R9";
        if (k == 18 || k == 19) return "R3";
        return "R11";
    endfunction

    logic [7:0] q[$];

    // model state: 0 waiting first byte, 1 collecting, 2 holding record
    int mstate = 0, need = 0, got = 0;
    int e_kind, e_dst, e_src, e_alu, e_cond, e_port, e_vec, e_len, e_imm, e_tgt;
    logic [7:0] ob0, ob1;
    bit  p_rst = 1'b1, p_valid = 1'b0, p_oready = 1'b0;
    logic [7:0] p_byte = 8'd0;
    logic [15:0] lf = 16'hACE1;
    int  cyc = 0;
    bit  did_mid = 1'b0, mid_now = 1'b0, after_mid = 1'b0;

    initial begin
        int k, d, s, a, c, p, v, len;
        for (int op = 0; op < 256; op++) begin
            q.push_back(8'(op));
            ref_decode(8'(op), k, d, s, a, c, p, v, len);
            for (int j = 1; j < len; j++) q.push_back(8'((op * 7 + j * 37 + 11) & 255));
        end
        // directed branches and immediates with distinctive operands
        q.push_back(8'h44); q.push_back(8'hEF); q.push_back(8'hBE);
        q.push_back(8'h7A); q.push_back(8'h01); q.push_back(8'h80);
        q.push_back(8'h3E); q.push_back(8'hA5);
        q.push_back(8'h24); q.push_back(8'hFF);
    end

    always @(negedge clk) begin
        string rq;
        cyc++;
        // advance the model with the inputs sampled at the last edge
        if (p_rst) begin
            mstate = 0;
        end else begin
            case (mstate)
                0: if (p_valid) begin
                    void'(q.pop_front());
                    ref_decode(p_byte, e_kind, e_dst, e_src, e_alu, e_cond,
                               e_port, e_vec, e_len);
                    need = e_len - 1; got = 0;
                    e_imm = 0;
                    e_tgt = (e_kind == 11) ? e_vec : 0;
                    mstate = (need == 0) ? 2 : 1;
                end
                1: if (p_valid) begin
                    void'(q.pop_front());
                    if (got == 0) ob0 = p_byte; else ob1 = p_byte;
                    got++;
                    if (got == need) begin
                        if (e_kind == 7 || e_kind == 8) e_imm = ob0;
                        if (e_kind >= 12 && e_kind <= 15) e_tgt = {ob1, ob0};
                        mstate = 2;
                    end
                end
                default: if (p_oready) mstate = 0;
            endcase
        end

        // compare against the design
        rq = after_mid ? "R2" : "R1";
        chk(in_ready == (mstate != 2), rq, "in_ready", in_ready, mstate != 2);
        chk(out_valid == (mstate == 2), rq, "out_valid", out_valid, mstate == 2);
        after_mid = 1'b0;
        if (mstate == 2 && out_valid) begin
            rq = req_for(e_kind);
            chk(out_kind == e_kind, rq, "kind", out_kind, e_kind);
            chk(out_len == e_len, rq, "len", out_len, e_len);
            chk(out_dst == e_dst && out_src == e_src, rq, "dst/src",
                {out_dst, out_src}, (e_dst << 3) | e_src);
            chk(out_alu == e_alu && out_cond == e_cond, rq, "alu/cond",
                {out_alu, out_cond}, (e_alu << 3) | e_cond);
            chk(out_port == e_port, rq, "port", out_port, e_port);
            chk(out_illegal == (e_kind == 20), "R11", "illegal", out_illegal, e_kind == 20);
            // R12: unused imm/target read zero; else the value itself
            chk(out_imm == e_imm, (e_imm == 0) ? "R12" : rq, "imm", out_imm, e_imm);
            chk(out_target == e_tgt, (e_tgt == 0) ? "R12" : rq, "target", out_target, e_tgt);
        end

        // drive the next inputs
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        mid_now = (!did_mid && cyc > 300 && mstate == 1 && need == 2 && got == 0);
        if (mid_now) begin did_mid = 1'b1; after_mid = 1'b1; end
        rst       = (cyc < 4) || mid_now;
        in_valid  = !rst && (q.size() > 0) && (lf[0] || lf[3]);
        in_byte   = (q.size() > 0) ? q[0] : 8'd0;
        out_ready = lf[5] || lf[7];
        p_rst = rst; p_valid = in_valid; p_byte = in_byte; p_oready = out_ready;

        if (cyc > 10 && q.size() == 0 && mstate == 0 && did_mid) begin
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
        if (cyc > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule